// File: doc/BRIEF.md
# Quadrature-Capable 16-Bit Timer Channel

This block is a single 16-bit timer channel with a small register port. It has three ways to drive its counter. In the internal mode the counter runs from the system clock through a power-of-two prescaler. In the external mode it counts selected edges of input A. In the phase mode it decodes the two external inputs A and B as a quadrature pair and counts up or down by one on every edge, depending on the direction of rotation.

Two general registers, GRA and GRB, are compared against the counter whenever it is about to move. A match can clear the counter, set a sticky flag, and, when PWM is enabled, drive the output pin high (GRA) or low (GRB). Clearing and compare logic stay active in phase mode. The prescaler and edge-select fields are ignored there. A flag-direction bit decides whether an underflow also raises the overflow flag. A flag is cleared by reading it as 1 and then writing 0 to it.

Top module: `qtmr_channel`

Register map (word address on `addr_i`):
- 0: control
- 1: status
- 2: counter
- 3: GRA
- 4: GRB

Control bits:
- [0] PWM enable
- [1] phase mode
- [2] overflow-only
- [4:3] reserved, read as 1
- [6:5] clear select: 0 none, 1 on GRA match, 2 on GRB match
- [7] external clock on A
- [9:8] edge select: 0 rising, 1 falling, 2 or 3 both
- [11:10] prescale: divide by 2^n
- [14:12] interrupt enables for {GRB match, GRA match, overflow}
- [15] reads 0

Status bits:
- [0] overflow
- [1] GRA match
- [2] GRB match

## Requirements
- R1: After reset, the registers read as follows: control 0x0018, counter 0x0000, GRA 0xFFFF, GRB 0xFFFF, status 0. `pwm_o`, `ovf_o`, `cma_o`, `cmb_o` and `irq_o` are all 0.
- R2: Control bits [4:3] always read as 1, whatever value is written to them.
- R3: In internal mode (control bits [7] and [1] both 0), the counter rises by exactly one every 2^n system clocks, where n is control bits [11:10].
- R4: In external mode (bit [7]=1, bit [1]=0), the counter rises by one on each edge of A chosen by bits [9:8]: 0 counts rising edges, 1 counts falling edges, 2 counts both.
- R5: In phase mode (bit [1]=1), the counter rises by one when any of these happens:
  - B rises while A is low
  - A rises while B is high
  - B falls while A is high
  - A falls while B is low
- R6: In phase mode, the counter falls by one when any of these happens:
  - A rises while B is low
  - B rises while A is high
  - A falls while B is high
  - B falls while A is low
- R7: In phase mode, control bits [7], [9:8] and [11:10] have no effect on counting.
- R8: Overflow (0xFFFF counting up to 0x0000) always sets status bit 0. Underflow (0x0000 counting down to 0xFFFF) sets it only when control bit [2] is 0.
- R9: A count event while the counter equals GRA (or GRB) sets status bit 1 (or 2). If the clear select names that register, the counter goes to 0 instead of stepping. This holds in phase mode too.
- R10: With PWM enabled, `pwm_o` goes to 1 on a GRA match and to 0 on a GRB match. If both match together, it goes to 0. With PWM disabled, `pwm_o` is 0.
- R11: Flags are sticky.
  - Writing 0 to a status bit clears it only if that bit was read as 1 since it was last cleared.
  - A set event in the same cycle as a valid clear leaves the flag set.
- R12: `irq_o` is the OR over the three flags, each gated by its enable bit in control [14:12].
- R13: A counter write takes precedence over any count or clear event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe; data appears on `rdata_o` one cycle later |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| tclk_a_i | input | 1 | External input A, asynchronous |
| tclk_b_i | input | 1 | External input B, asynchronous |
| pwm_o | output | 1 | PWM/compare output |
| ovf_o | output | 1 | Overflow flag |
| cma_o | output | 1 | GRA match flag |
| cmb_o | output | 1 | GRB match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- The counter only holds, steps by one, returns to zero, or takes a written value.
- A set flag stays set until its status word is written.
- `irq_o` is never raised without a flag behind it.
- `pwm_o` stays low while PWM is disabled.
- The reserved control bits always read back as 1.

Only the bench scenarios can show the following:
- The exact quadrature direction table.
- The prescaler rates and the edge-select choices.
- Whether underflow raises the overflow flag.
- The read-then-write clear handshake, including a set that collides with a clear.
- The PWM duty cycle and the tie case when GRA and GRB match together.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_CNT  = 3'd2;
  localparam logic [2:0] ADDR_GRA  = 3'd3;
  localparam logic [2:0] ADDR_GRB  = 3'd4;

  typedef enum logic [1:0] {CLR_NONE = 2'd0, CLR_GRA = 2'd1, CLR_GRB = 2'd2, CLR_RSV = 2'd3} clr_sel_e;

  typedef struct packed {
    logic [2:0] ie;       // {cmb, cma, ovf}
    logic [1:0] psc;
    logic [1:0] edge_sel;
    logic       ext_clk;
    clr_sel_e   clr_sel;
    logic       ovf_only;
    logic       phase_en;
    logic       pwm_en;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [15:0] w);
    ctrl_t c;
    c.pwm_en   = w[0];
    c.phase_en = w[1];
    c.ovf_only = w[2];
    c.clr_sel  = clr_sel_e'(w[6:5]);
    c.ext_clk  = w[7];
    c.edge_sel = w[9:8];
    c.psc      = w[11:10];
    c.ie       = w[14:12];
    return c;
  endfunction

  function automatic logic [15:0] ctrl_pack(input ctrl_t c);
    return {1'b0, c.ie, c.psc, c.edge_sel, c.ext_clk, c.clr_sel, 2'b11,
            c.ovf_only, c.phase_en, c.pwm_en};
  endfunction
endpackage

// File: rtl/qtmr_sync_edge.sv
module qtmr_sync_edge #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], async_i[g]};
        prev_q <= sh_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = sh_q[STAGES-1];
    assign rise_o[g] = sh_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~sh_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/qtmr_tick_gen.sv
module qtmr_tick_gen #(
  parameter int unsigned PSC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_en_i,
  input  logic             ext_clk_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             a_lvl_i,
  input  logic             b_lvl_i,
  input  logic             a_rise_i,
  input  logic             a_fall_i,
  input  logic             b_rise_i,
  input  logic             b_fall_i,
  output logic             up_o,
  output logic             dn_o
);
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] mask;
  logic             int_tick, ext_tick, q_up, q_dn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_q + 1'b1;
  end

  assign mask     = ~({DIV_W{1'b1}} << psc_i);
  assign int_tick = (pcnt_q & mask) == mask;

  always_comb begin
    unique case (edge_sel_i)
      2'd0:    ext_tick = a_rise_i;
      2'd1:    ext_tick = a_fall_i;
      default: ext_tick = a_rise_i | a_fall_i;
    endcase
  end

  assign q_up = (b_rise_i & ~a_lvl_i) | (a_rise_i & b_lvl_i) |
                (b_fall_i & a_lvl_i)  | (a_fall_i & ~b_lvl_i);
  assign q_dn = (a_rise_i & ~b_lvl_i) | (b_rise_i & a_lvl_i) |
                (a_fall_i & b_lvl_i)  | (b_fall_i & ~a_lvl_i);

  assign up_o = phase_en_i ? q_up : (ext_clk_i ? ext_tick : int_tick);
  assign dn_o = phase_en_i & q_dn & ~q_up;
endmodule

// File: rtl/qtmr_count_core.sv
module qtmr_count_core
  import qtmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic [W-1:0] gra_i,
  input  logic [W-1:0] grb_i,
  input  clr_sel_e     clr_sel_i,
  input  logic         pwm_en_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_ev_o,
  output logic         unf_ev_o,
  output logic         cma_ev_o,
  output logic         cmb_ev_o,
  output logic         pwm_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         tick, clr, pwm_q;

  assign tick     = (up_i | dn_i) & ~cnt_we_i;
  assign cma_ev_o = tick & (cnt_q == gra_i);
  assign cmb_ev_o = tick & (cnt_q == grb_i);
  assign clr      = ((clr_sel_i == CLR_GRA) & cma_ev_o) | ((clr_sel_i == CLR_GRB) & cmb_ev_o);
  assign ovf_ev_o = tick & up_i & ~clr & (cnt_q == '1);
  assign unf_ev_o = tick & ~up_i & ~clr & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we_i)  cnt_d = cnt_wdata_i;
    else if (clr)  cnt_d = '0;
    else if (up_i) cnt_d = cnt_q + 1'b1;
    else if (dn_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (!pwm_en_i)                pwm_q <= 1'b0;
      else if (cma_ev_o & cmb_ev_o) pwm_q <= 1'b0;
      else if (cma_ev_o)            pwm_q <= 1'b1;
      else if (cmb_ev_o)            pwm_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;
endmodule

// File: rtl/qtmr_channel.sv
module qtmr_channel
  import qtmr_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned AW    = 3,
  parameter int unsigned SYNC  = 2,
  parameter int unsigned NFLAG = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic          tclk_a_i,
  input  logic          tclk_b_i,
  output logic          pwm_o,
  output logic          ovf_o,
  output logic          cma_o,
  output logic          cmb_o,
  output logic          irq_o
);
  ctrl_t            ctrl_q;
  logic [W-1:0]     gra_q, grb_q, rdata_q, cnt;
  logic [NFLAG-1:0] flags_q, armed_q, flag_set, flag_clr;
  logic [1:0]       lvl, rise, fall;
  logic             up, dn, ovf_ev, unf_ev, cma_ev, cmb_ev;
  logic             wr_ctrl, wr_stat, wr_cnt, wr_gra, wr_grb, rd_stat;

  assign wr_ctrl = we_i && addr_i == AW'(ADDR_CTRL);
  assign wr_stat = we_i && addr_i == AW'(ADDR_STAT);
  assign wr_cnt  = we_i && addr_i == AW'(ADDR_CNT);
  assign wr_gra  = we_i && addr_i == AW'(ADDR_GRA);
  assign wr_grb  = we_i && addr_i == AW'(ADDR_GRB);
  assign rd_stat = re_i && addr_i == AW'(ADDR_STAT);

  qtmr_sync_edge #(.N(2), .STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni,
    .async_i ({tclk_b_i, tclk_a_i}),
    .lvl_o   (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  qtmr_tick_gen #(.PSC_W(2)) u_tick (
    .clk_i, .rst_ni,
    .phase_en_i (ctrl_q.phase_en),
    .ext_clk_i  (ctrl_q.ext_clk),
    .edge_sel_i (ctrl_q.edge_sel),
    .psc_i      (ctrl_q.psc),
    .a_lvl_i    (lvl[0]),
    .b_lvl_i    (lvl[1]),
    .a_rise_i   (rise[0]),
    .a_fall_i   (fall[0]),
    .b_rise_i   (rise[1]),
    .b_fall_i   (fall[1]),
    .up_o       (up),
    .dn_o       (dn)
  );

  qtmr_count_core #(.W(W)) u_core (
    .clk_i, .rst_ni,
    .up_i        (up),
    .dn_i        (dn),
    .cnt_we_i    (wr_cnt),
    .cnt_wdata_i (wdata_i),
    .gra_i       (gra_q),
    .grb_i       (grb_q),
    .clr_sel_i   (ctrl_q.clr_sel),
    .pwm_en_i    (ctrl_q.pwm_en),
    .cnt_o       (cnt),
    .ovf_ev_o    (ovf_ev),
    .unf_ev_o    (unf_ev),
    .cma_ev_o    (cma_ev),
    .cmb_ev_o    (cmb_ev),
    .pwm_o       (pwm_o)
  );

  assign flag_set = {cmb_ev, cma_ev, ovf_ev | (unf_ev & ~ctrl_q.ovf_only)};
  assign flag_clr = wr_stat ? (armed_q & ~wdata_i[NFLAG-1:0]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      gra_q   <= '1;
      grb_q   <= '1;
      flags_q <= '0;
      armed_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_unpack(wdata_i[15:0]);
      if (wr_gra)  gra_q  <= wdata_i;
      if (wr_grb)  grb_q  <= wdata_i;
      flags_q <= flag_set | (flags_q & ~flag_clr);
      if (rd_stat)      armed_q <= flags_q;
      else if (wr_stat) armed_q <= armed_q & ~flag_clr;
      if (re_i) begin
        unique case (addr_i)
          AW'(ADDR_CTRL): rdata_q <= W'(ctrl_pack(ctrl_q));
          AW'(ADDR_STAT): rdata_q <= W'(flags_q);
          AW'(ADDR_CNT):  rdata_q <= cnt;
          AW'(ADDR_GRA):  rdata_q <= gra_q;
          AW'(ADDR_GRB):  rdata_q <= grb_q;
          default:        rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
  assign ovf_o   = flags_q[0];
  assign cma_o   = flags_q[1];
  assign cmb_o   = flags_q[2];
  assign irq_o   = |(flags_q & ctrl_q.ie);
endmodule

// File: rtl/qtmr_channel_chk.sv
module qtmr_channel_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic        re_i,
  input logic [2:0]  addr_i,
  input logic [15:0] rdata_o,
  input logic        pwm_o,
  input logic        ovf_o,
  input logic        cma_o,
  input logic        cmb_o,
  input logic        irq_o,
  input logic        pwm_en_i,
  input logic [15:0] cnt_i
);
  AST_RSV_READ_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 3'd0) |=> rdata_o[4:3] == 2'b11); // R2

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 3'd2) |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 16'd1 ||
                                  cnt_i == $past(cnt_i) - 16'd1 || cnt_i == 16'd0)); // R3

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(we_i && addr_i == 3'd1)) |=> ovf_o); // R11

  AST_CMA_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cma_o && !(we_i && addr_i == 3'd1)) |=> cma_o); // R11

  AST_PWM_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_en_i |=> !pwm_o); // R10

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_o || cma_o || cmb_o)); // R12
endmodule

bind qtmr_channel qtmr_channel_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .re_i     (re_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .pwm_o    (pwm_o),
  .ovf_o    (ovf_o),
  .cma_o    (cma_o),
  .cmb_o    (cmb_o),
  .irq_o    (irq_o),
  .pwm_en_i (ctrl_q.pwm_en),
  .cnt_i    (cnt)
);

// File: tb/tb_qtmr_channel.sv
`timescale 1ns/1ps
module tb_qtmr_channel;
  logic        clk = 0, rst_ni = 0;
  logic        we = 0, re = 0, ta = 0, tb = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        pwm, ovf, cma, cmb, irq;
  int          total = 0, bad = 0;
  logic [15:0] v, v0;
  int          hi;

  always #2 clk = ~clk;

  qtmr_channel dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tclk_a_i(ta), .tclk_b_i(tb),
    .pwm_o(pwm), .ovf_o(ovf), .cma_o(cma), .cmb_o(cmb), .irq_o(irq)
  );

  // {a, b, expected counter}; starts from counter 100 with a=b=0
  localparam logic [17:0] QVEC [12] = '{
    {1'b0, 1'b1, 16'd101}, {1'b1, 1'b1, 16'd102}, {1'b1, 1'b0, 16'd103}, {1'b0, 1'b0, 16'd104},
    {1'b1, 1'b0, 16'd103}, {1'b1, 1'b1, 16'd102}, {1'b0, 1'b1, 16'd101}, {1'b0, 1'b0, 16'd100},
    {1'b1, 1'b0, 16'd99},  {1'b1, 1'b1, 16'd98},  {1'b1, 1'b0, 16'd99},  {1'b0, 1'b0, 16'd100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    re = 1; addr = a;
    @(negedge clk);
    re = 0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_flags();
    logic [15:0] s;
    rd(3'd1, s);
    wr(3'd1, 16'h0000);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm", pwm, 0); chk("R1 flags", {ovf, cma, cmb, irq}, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0018);
    rd(3'd3, v); chk("R1 gra", v, 16'hFFFF);
    rd(3'd4, v); chk("R1 grb", v, 16'hFFFF);
    rd(3'd1, v); chk("R1 status", v, 0);
    rd(3'd2, v); chk("R1 counter runs from 0", (v < 16'd20), 1);

    // R2 reserved bits
    wr(3'd0, 16'h0000); rd(3'd0, v); chk("R2 ctrl 0", v, 16'h0018);

    // R13 counter write beats counting
    wr(3'd2, 16'h1234);
    rd(3'd2, v); chk("R13 written value", v, 16'h1234);
    rd(3'd2, v); chk("R13 next step", v, 16'h1235);

    // R3 prescaler rates
    for (int p = 0; p < 4; p++) begin
      wr(3'd0, 16'(p << 10));
      settle();
      rd(3'd2, v0);
      repeat (63) @(negedge clk);
      rd(3'd2, v);
      chk($sformatf("R3 psc=%0d", p), 16'(v - v0), 16'(64 >> p));
    end

    // R4 external A edges
    for (int e = 0; e < 3; e++) begin
      ta = 0;
      wr(3'd0, 16'h0080 | 16'(e << 8));
      settle();
      rd(3'd2, v0);
      for (int k = 0; k < 3; k++) begin
        ta = 1; settle(); ta = 0; settle();
      end
      rd(3'd2, v);
      chk($sformatf("R4 edge_sel=%0d", e), 16'(v - v0), (e == 2) ? 16'd6 : 16'd3);
    end

    // R5 R6 R7 quadrature table, with prescale/edge/ext bits set and ignored
    ta = 0; tb = 0;
    wr(3'd0, 16'h0E82);
    settle();
    wr(3'd2, 16'd100);
    for (int i = 0; i < 12; i++) begin
      ta = QVEC[i][17]; tb = QVEC[i][16];
      settle();
      rd(3'd2, v);
      chk($sformatf("R5 R6 R7 step %0d", i), v, QVEC[i][15:0]);
    end
    clear_flags();

    // R8 overflow / underflow (a=b=0 now)
    wr(3'd0, 16'h0006);                   // phase, overflow-only
    wr(3'd2, 16'hFFFF);
    tb = 1; settle();                     // up
    rd(3'd2, v); chk("R8 wrap up", v, 16'h0000);
    chk("R8 overflow sets", ovf, 1);
    clear_flags();
    chk("R11 read then write clears", ovf, 0);
    wr(3'd2, 16'h0000);
    tb = 0; settle();                     // B falls, A low: down
    rd(3'd2, v); chk("R8 wrap down", v, 16'hFFFF);
    chk("R8 underflow ignored when overflow-only", ovf, 0);
    wr(3'd0, 16'h0002);
    wr(3'd2, 16'h0000);
    ta = 1; settle();                     // A rises, B low: down
    chk("R8 underflow sets when bit2=0", ovf, 1);

    // R11 write without prior read keeps flag
    wr(3'd1, 16'h0000);
    chk("R11 unarmed write keeps flag", ovf, 1);
    rd(3'd1, v); chk("R11 status read", v[0], 1);
    wr(3'd1, 16'h0000);
    chk("R11 armed write clears", ovf, 0);
    // R11 set collides with clear (a=1,b=0)
    wr(3'd2, 16'hFFFF);
    ta = 0; settle();                     // A falls, B low: up -> 0 with overflow
    rd(3'd1, v); chk("R11 armed before collision", v[0], 1);
    wr(3'd2, 16'hFFFF);
    ta = 1; settle();                     // down to FFFE
    rd(3'd1, v);
    wr(3'd2, 16'hFFFF);
    ta = 0;
    @(negedge clk); @(negedge clk);
    wr(3'd1, 16'h0000);                   // same edge as the up tick
    chk("R11 set wins over clear", ovf, 1);
    rd(3'd2, v); chk("R11 collision counter", v, 16'h0000);
    clear_flags();
    clear_flags();

    // R9 compare clear in phase mode (a=b=0)
    wr(3'd0, 16'h0022);                   // phase, clear on GRA
    wr(3'd3, 16'd3);
    wr(3'd2, 16'd2);
    tb = 1; settle();
    rd(3'd2, v); chk("R9 reach GRA", v, 16'd3);
    chk("R9 no match yet", cma, 0);
    ta = 1; settle();
    rd(3'd2, v); chk("R9 cleared on GRA", v, 16'd0);
    chk("R9 GRA flag", cma, 1);
    clear_flags();

    // R12 interrupt gating (a=1,b=1 -> down step is B falls while A high? that is up)
    wr(3'd0, 16'h1002);
    wr(3'd2, 16'hFFFF);
    tb = 0; settle();                     // up -> overflow
    chk("R12 irq enabled", irq, 1);
    wr(3'd0, 16'h0002);
    chk("R12 irq masked", irq, 0);
    chk("R12 flag still set", ovf, 1);

    // R10 PWM
    wr(3'd3, 16'd2); wr(3'd4, 16'd5);
    wr(3'd0, 16'h0041);                   // internal, clear on GRB, pwm
    wr(3'd2, 16'd0);
    repeat (20) @(negedge clk);
    hi = 0;
    for (int c = 0; c < 60; c++) begin @(negedge clk); hi += int'(pwm); end
    chk("R10 duty 3 of 6", hi, 30);
    wr(3'd4, 16'd4); wr(3'd3, 16'd4);
    repeat (20) @(negedge clk);
    hi = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); hi += int'(pwm); end
    chk("R10 tie drives low", hi, 0);
    wr(3'd3, 16'd2); wr(3'd4, 16'd5);
    wr(3'd0, 16'h0040);
    hi = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); hi += int'(pwm); end
    chk("R10 disabled low", hi, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule